// File: doc/BRIEF.md
# Single-Pulse Interrupt Acknowledge Responder

This block decides, for one channel of a serial controller, whether to answer an interrupt acknowledge cycle that the host signals with a dedicated low-going acknowledge strobe. It is used instead of a daisy-chain scheme. At the falling edge of that strobe it captures the enable-in qualifier and the channel's pending-interrupt state. From that snapshot it either drives an 8-bit vector on the low data lines, paced by a wait/ready handshake, or stays off the bus for the whole cycle.

All strobes come in asynchronously. They pass through a synchronizer, and every decision is taken in the clock domain. The read and data strobes must stay inactive for the whole cycle. On an address/data multiplexed bus, the acknowledge strobe must also arrive a minimum number of clocks after the address strobe has ended. The interrupt request output is a dedicated, actively driven line, so that arbitration logic outside the block can tell this channel apart from other requesters.

Top module: `sp_iack_responder`

## Requirements
- R1: While `two_pulse_mode` is 1, an acknowledge falling edge never makes the block drive the bus (`vec_oe` stays 0, `wait_rdy_n` stays 1).
- R2: If `ien` is 1 and `irq_pend` is 1 when the synchronized `ack_n` falls (with `rd_n`/`ds_n` high and any bus-gap rule met), `vec_oe` goes to 1 exactly SYNC_STAGES+1 clocks after `ack_n` is sampled low.
- R3: If `ien` is 0 at the acknowledge falling edge, the whole cycle is ignored: `vec_oe` stays 0 and `wait_rdy_n` stays 1.
- R4: If `irq_pend` is 0 at the acknowledge falling edge, the whole cycle is ignored in the same way.
- R5: With `ready_mode` = 0 (wait semantics), `wait_rdy_n` is 0 from the start of the response for VALID_DLY clocks and then returns to 1 while the vector is valid. With `ready_mode` = 1 (ready semantics), `wait_rdy_n` is 1 first and goes to 0 once the vector is valid.
- R6: `vec_out` carries `vec_in` as it was at the falling edge and stays at that value until release. Later changes of `vec_in` or `irq_pend` have no effect on the cycle in progress.
- R7: After `ack_n` rises, `vec_oe` returns to 0 and `wait_rdy_n` returns to 1 within SYNC_STAGES+1 clocks. `vec_out` reads 0 while not enabled.
- R8: If `rd_n` or `ds_n` is low at the falling edge, or goes low during the response, the block does not respond or stops responding, and stays silent until `ack_n` rises.
- R9: With `muxed_bus` = 1, a falling edge that comes fewer than GAP_MIN clocks after `as_n` rose, or while `as_n` is low, is ignored. With `muxed_bus` = 0 the gap is not checked.
- R10: `irq_n` is the active-low, registered copy of `irq_pend`, delayed by one clock, and it is driven actively at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_n | input | 1 | Dedicated acknowledge strobe, active low |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low (must stay high in cycle) |
| ds_n | input | 1 | Data strobe, active low (must stay high in cycle) |
| ien | input | 1 | Enable-in qualifier sampled at acknowledge fall |
| two_pulse_mode | input | 1 | 1 selects the other acknowledge mode; block stays silent |
| ready_mode | input | 1 | 0 = wait semantics, 1 = ready semantics on `wait_rdy_n` |
| muxed_bus | input | 1 | 1 enables the address-strobe gap check |
| irq_pend | input | 1 | Internal pending-interrupt state |
| vec_in | input | VEC_W | Vector to present |
| vec_out | output | VEC_W | Vector on low data lines (0 when not enabled) |
| vec_oe | output | 1 | Data-line output enable |
| wait_rdy_n | output | 1 | Wait/ready handshake, active low |
| irq_n | output | 1 | Dedicated interrupt request, active low |

## Verification
The bench aims at the decision point. It varies enable-in, the pending state and the mode bit one at a time, so that a design which sampled the wrong qualifier, or kept sampling after the edge, would drive the bus when it should not, or lose the vector. It drives both wait/ready semantics, so that a polarity mix-up shows as the handshake being low in the wrong phase. On the multiplexed bus it places the acknowledge just after the address strobe. A design without the gap check would answer there, and one that applied the check on a non-multiplexed bus would stay silent. A read strobe that drops mid-response must end the response: a design that ignored it would keep driving the bus.

// File: rtl/iack_pkg.sv
package iack_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PEND  = 2'd1,
      ST_VALID = 2'd2,
      ST_SKIP  = 2'd3
   } iack_state_e;
endpackage

// File: rtl/iack_sync.sv
module iack_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/iack_gap_timer.sv
module iack_gap_timer #(
   parameter int GAP_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_hi,
   output logic gap_ok
);
   localparam int CW = $clog2(GAP_MIN + 2);
   localparam logic [CW-1:0] LIMIT = CW'(GAP_MIN);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= LIMIT;
      else if (!as_hi)        cnt <= '0;
      else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
   end

   assign gap_ok = as_hi && (cnt == LIMIT);
endmodule

// File: rtl/iack_fsm.sv
module iack_fsm
   import iack_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int VALID_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_fall,
   input  logic             ack_rise,
   input  logic             strobes_ok,
   input  logic             ien_s,
   input  logic             irq_pend,
   input  logic             gap_ok,
   input  logic             muxed_bus,
   input  logic             two_pulse_mode,
   input  logic             ready_mode,
   input  logic [VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_oe,
   output logic             wait_rdy_n,
   output iack_state_e      state
);
   localparam int DW = $clog2(VALID_DLY + 1);
   localparam logic [DW-1:0] DLY_LAST = DW'(VALID_DLY - 1);

   iack_state_e      nxt;
   logic [DW-1:0]    dly_cnt;
   logic [VEC_W-1:0] vec_q;
   logic             accept;

   assign accept = !two_pulse_mode && ien_s && irq_pend && strobes_ok
                   && (!muxed_bus || gap_ok);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (ack_fall) nxt = accept ? ST_PEND : ST_SKIP;
         ST_PEND: begin
            if (ack_rise)                 nxt = ST_IDLE;
            else if (!strobes_ok)         nxt = ST_SKIP;
            else if (dly_cnt == DLY_LAST) nxt = ST_VALID;
         end
         ST_VALID: begin
            if (ack_rise)         nxt = ST_IDLE;
            else if (!strobes_ok) nxt = ST_SKIP;
         end
         ST_SKIP:  if (ack_rise) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dly_cnt <= '0;
         vec_q   <= '0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && ack_fall) begin
            vec_q   <= vec_in;
            dly_cnt <= '0;
         end else if (state == ST_PEND) begin
            dly_cnt <= dly_cnt + 1'b1;
         end
      end
   end

   assign vec_oe     = (state == ST_PEND) || (state == ST_VALID);
   assign vec_out    = vec_oe ? vec_q : '0;
   assign wait_rdy_n = ready_mode ? (state != ST_VALID) : (state != ST_PEND);
endmodule

// File: rtl/sp_iack_responder.sv
module sp_iack_responder
   import iack_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_MIN     = 3,
   parameter int VALID_DLY   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_n,
   input  logic             as_n,
   input  logic             rd_n,
   input  logic             ds_n,
   input  logic             ien,
   input  logic             two_pulse_mode,
   input  logic             ready_mode,
   input  logic             muxed_bus,
   input  logic             irq_pend,
   input  logic [VEC_W-1:0] vec_in,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_oe,
   output logic             wait_rdy_n,
   output logic             irq_n
);
   localparam int NSIG = 5;
   localparam logic [NSIG-1:0] SYNC_RST = 5'b11110;

   generate
      if (VEC_W < 1)       begin : g_bad_w   $error("VEC_W must be at least 1");     end
      if (SYNC_STAGES < 0) begin : g_bad_s   $error("SYNC_STAGES must be >= 0");     end
      if (GAP_MIN < 1)     begin : g_bad_g   $error("GAP_MIN must be at least 1");   end
      if (VALID_DLY < 1)   begin : g_bad_d   $error("VALID_DLY must be at least 1"); end
   endgenerate

   logic [NSIG-1:0] raw_s, syn_s;
   logic            s_ack, s_as, s_rd, s_ds, s_ien;
   logic            ack_prev, ack_fall, ack_rise, gap_ok, strobes_ok;
   iack_state_e     state;

   assign raw_s = {ack_n, as_n, rd_n, ds_n, ien};

   iack_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_s), .q(syn_s)
   );

   assign {s_ack, s_as, s_rd, s_ds, s_ien} = syn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_prev <= 1'b1;
         irq_n    <= 1'b1;
      end else begin
         ack_prev <= s_ack;
         irq_n    <= !irq_pend;
      end
   end

   assign ack_fall   = ack_prev && !s_ack;
   assign ack_rise   = !ack_prev && s_ack;
   assign strobes_ok = s_rd && s_ds;

   iack_gap_timer #(.GAP_MIN(GAP_MIN)) u_gap (
      .clk(clk), .rst_n(rst_n), .as_hi(s_as), .gap_ok(gap_ok)
   );

   iack_fsm #(.VEC_W(VEC_W), .VALID_DLY(VALID_DLY)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ack_fall(ack_fall), .ack_rise(ack_rise), .strobes_ok(strobes_ok),
      .ien_s(s_ien), .irq_pend(irq_pend), .gap_ok(gap_ok),
      .muxed_bus(muxed_bus), .two_pulse_mode(two_pulse_mode),
      .ready_mode(ready_mode), .vec_in(vec_in),
      .vec_out(vec_out), .vec_oe(vec_oe), .wait_rdy_n(wait_rdy_n),
      .state(state)
   );
endmodule

// File: rtl/iack_resp_chk.sv
module iack_resp_chk #(
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_fall,
   input logic             s_ien,
   input logic             s_rd,
   input logic             s_ds,
   input logic             irq_pend,
   input logic             two_pulse_mode,
   input logic             vec_oe,
   input logic             wait_rdy_n,
   input logic [VEC_W-1:0] vec_out,
   input logic             irq_n
);
   // R2/R3/R4: a response starts only from a qualified falling edge
   a_r3_oe_needs_qualified_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_oe) |-> ($past(ack_fall) && $past(s_ien) && $past(irq_pend)));

   // R1: the other acknowledge mode never starts a response
   a_r1_two_pulse_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_oe) |-> !$past(two_pulse_mode));

   // R8: a low read or data strobe ends the response at the next edge
   a_r8_strobe_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_rd || !s_ds) |=> !vec_oe);

   // R6: vector held stable while driven
   a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

   // R5: handshake asserted only during a response
   a_r5_hs_within_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_rdy_n |-> vec_oe);

   // R10: request output tracks the pending state one clock later
   a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n == !$past(irq_pend)));
endmodule

bind sp_iack_responder iack_resp_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack_fall(ack_fall), .s_ien(s_ien),
   .s_rd(s_rd), .s_ds(s_ds), .irq_pend(irq_pend),
   .two_pulse_mode(two_pulse_mode), .vec_oe(vec_oe),
   .wait_rdy_n(wait_rdy_n), .vec_out(vec_out), .irq_n(irq_n)
);

// File: tb/tb_sp_iack_responder.sv
`timescale 1ns/1ps
module tb_sp_iack_responder;
   localparam int VEC_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ack_n = 1'b1, as_n = 1'b1, rd_n = 1'b1, ds_n = 1'b1;
   logic ien = 1'b0, two_pulse_mode = 1'b0, ready_mode = 1'b0, muxed_bus = 1'b0;
   logic irq_pend = 1'b0;
   logic [VEC_W-1:0] vec_in = '0;
   logic [VEC_W-1:0] vec_out;
   logic vec_oe, wait_rdy_n, irq_n;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   sp_iack_responder #(.VEC_W(VEC_W), .SYNC_STAGES(2), .GAP_MIN(3), .VALID_DLY(2)) dut (
      .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .as_n(as_n), .rd_n(rd_n), .ds_n(ds_n),
      .ien(ien), .two_pulse_mode(two_pulse_mode), .ready_mode(ready_mode),
      .muxed_bus(muxed_bus), .irq_pend(irq_pend), .vec_in(vec_in),
      .vec_out(vec_out), .vec_oe(vec_oe), .wait_rdy_n(wait_rdy_n), .irq_n(irq_n)
   );

   typedef struct packed {
      logic       tp;
      logic       rdy;
      logic       mux;
      logic [3:0] gap;
      logic       en;
      logic       irq;
      logic       exp;
   } row_t;

   // tp rdy mux gap en irq exp
   localparam row_t ROWS [8] = '{
      '{1'b0, 1'b0, 1'b0, 4'd8, 1'b1, 1'b1, 1'b1},   // R2 R5 wait semantics
      '{1'b0, 1'b1, 1'b0, 4'd8, 1'b1, 1'b1, 1'b1},   // R5 ready semantics
      '{1'b0, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 1'b0},   // R3 enable-in low
      '{1'b0, 1'b1, 1'b0, 4'd8, 1'b1, 1'b0, 1'b0},   // R4 nothing pending
      '{1'b1, 1'b0, 1'b0, 4'd8, 1'b1, 1'b1, 1'b0},   // R1 other mode
      '{1'b0, 1'b0, 1'b1, 4'd8, 1'b1, 1'b1, 1'b1},   // R9 gap met
      '{1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0},   // R9 gap too short
      '{1'b0, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b1}    // R9 gap ignored non-muxed
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Address strobe pulse, then the acknowledge fall after gap clocks
   task automatic start_cycle(input int gap);
      as_n = 1'b0;
      step(2);
      as_n = 1'b1;
      step(gap);
      ack_n = 1'b0;
   endtask

   task automatic end_cycle();
      ack_n = 1'b1;
      step(4);
      chk("R7 oe released", 32'(vec_oe), 32'd0);
      chk("R7 handshake released", 32'(wait_rdy_n), 32'd1);
      chk("R7 bus idle value", 32'(vec_out), 32'd0);
      step(6);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [VEC_W-1:0] v0;
      step(3);
      chk("reset oe", 32'(vec_oe), 32'd0);
      chk("reset handshake", 32'(wait_rdy_n), 32'd1);
      chk("reset vector", 32'(vec_out), 32'd0);
      rst_n = 1'b1;
      step(6);
      chk("R10 idle request", 32'(irq_n), 32'd1);

      for (int i = 0; i < 8; i++) begin
         two_pulse_mode = ROWS[i].tp;
         ready_mode     = ROWS[i].rdy;
         muxed_bus      = ROWS[i].mux;
         ien            = ROWS[i].en;
         irq_pend       = ROWS[i].irq;
         v0             = 8'h40 + 8'(i * 7);
         vec_in         = v0;
         step(4);
         start_cycle(int'(ROWS[i].gap));
         step(4);
         chk($sformatf("R2/R3/R4/R1/R9 row %0d respond", i), 32'(vec_oe), 32'(ROWS[i].exp));
         // R6: later changes must not matter
         vec_in   = ~v0;
         irq_pend = ~irq_pend;
         if (ROWS[i].exp) begin
            chk($sformatf("R5 row %0d early handshake", i), 32'(wait_rdy_n), 32'(ROWS[i].rdy));
            step(4);
            chk($sformatf("R5 row %0d late handshake", i), 32'(wait_rdy_n), 32'(!ROWS[i].rdy));
            chk($sformatf("R6 row %0d vector", i), 32'(vec_out), 32'(v0));
            chk($sformatf("R6 row %0d still driven", i), 32'(vec_oe), 32'd1);
         end else begin
            chk($sformatf("R3 row %0d no handshake", i), 32'(wait_rdy_n), 32'd1);
            step(4);
            chk($sformatf("R3 row %0d stays silent", i), 32'(vec_oe), 32'd0);
         end
         end_cycle();
      end

      // R8: read strobe dropping mid-response ends it
      two_pulse_mode = 1'b0; ready_mode = 1'b0; muxed_bus = 1'b0;
      ien = 1'b1; irq_pend = 1'b1; vec_in = 8'hA5;
      step(4);
      start_cycle(8);
      step(8);
      chk("R8 response before abort", 32'(vec_oe), 32'd1);
      rd_n = 1'b0;
      step(4);
      chk("R8 abort on read strobe", 32'(vec_oe), 32'd0);
      rd_n = 1'b1;
      step(4);
      chk("R8 stays silent after strobe returns", 32'(vec_oe), 32'd0);
      end_cycle();

      // R8: data strobe low at the falling edge
      ds_n = 1'b0;
      step(4);
      start_cycle(8);
      step(6);
      chk("R8 data strobe low at edge", 32'(vec_oe), 32'd0);
      ds_n = 1'b1;
      end_cycle();

      // R10: request line follows pending state
      irq_pend = 1'b1;
      step(2);
      chk("R10 request asserted", 32'(irq_n), 32'd0);
      irq_pend = 1'b0;
      step(2);
      chk("R10 request cleared", 32'(irq_n), 32'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule